// File: doc/BRIEF.md
# Sync-Framed Test Pattern Generator

This block produces an endless stream of fixed-length test frames. A ground-station receive chain uses them to check its frame synchronizer, correlator and recorder before live data arrives. Each frame is 2400 bytes long. It opens with an eight-byte synchronization code, then carries eight fixed header bytes, then a payload that counts upward from zero and restarts in every frame. A position counter tracks the byte index inside the frame. A frame counter counts how many frames have been completed.

By default the byte stream is paced by a built-in serializer, so that a bit-serial correlator can be driven directly. Each byte is presented on the parallel output for one cycle. The same byte is shifted out most significant bit first over eight enabled cycles, and the next byte is taken only when the last bit has gone. The enable input pauses everything, even in the middle of a byte, and the stream resumes exactly where it stopped. A parameter removes the serializer, and the byte stream then advances on every enabled cycle.

Top module: `tpg_frame_source`

## Requirements
- R1: Synchronous active-high reset clears every output to zero, including the frame count. The first byte sent after reset is frame position 0.
- R2: Frame positions 0 to 7 carry the synchronization bytes 0x0C, 0x28, 0xF2, 0x2C, 0xED, 0x7D, 0x0E, 0x24, in that order.
- R3: Frame positions 8 to 15 carry the fixed header byte 0xA0 plus the position, which gives 0xA8 through 0xAF.
- R4: Frame positions 16 to 2399 carry the payload byte (position − 16) modulo 256.
- R5: A frame holds exactly 2400 bytes. After position 2399 the next byte is position 0 of a new frame.
- R6: `sof` is high only in the cycle in which `byte_valid` presents position 0, and low in every other cycle.
- R7: `frame_count` steps up by exactly one on the clock edge that presents position 2399. Its value therefore equals the number of frames completed before the byte currently shown. It never changes at any other time.
- R8: Each byte leaves on `ser_bit` most significant bit first, over eight cycles with `ser_valid` high. Its first bit appears in the same cycle as `byte_valid`. The 64 serial bits that start at a `sof` read 0x0C28F22CED7D0E24.
- R9: While `en` is low, neither valid flag rises on the next edge and no state advances. When `en` returns, the stream continues from the exact bit where it paused.
- R10: `byte_valid` is high only on the first of each group of eight `ser_valid` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the stream by one bit (or one byte without the serializer) |
| byte_data | output | 8 | Current frame byte, valid when byte_valid is high |
| byte_valid | output | 1 | A new byte is presented this cycle |
| sof | output | 1 | The presented byte is the first synchronization byte |
| ser_bit | output | 1 | Serial data, most significant bit first |
| ser_valid | output | 1 | ser_bit carries a bit this cycle |
| frame_count | output | 24 | Number of completed frames, wraps silently |

## Verification
The frame counter step and the output of the last payload byte of a frame happen on the same clock edge. Eight enabled cycles later, that edge is followed by the start-of-frame marker. The stimulus carries the stream across two frame boundaries while the enable is toggled irregularly, so pauses land inside bytes and next to the wrap. The scoreboard predicts the count for every byte it pops: one higher exactly at position 2399, and unchanged at the following start-of-frame. Every byte is checked against the serial bits that follow it, so a step that is taken early, taken late or taken twice shows up.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int BYTE_W    = 8;
    localparam int SYNC_LEN  = 8;
    localparam int HDR_LEN   = 16;
    localparam int FRAME_LEN = 2400;
    localparam int FCNT_W    = 24;
    localparam logic [SYNC_LEN*BYTE_W-1:0] SYNC_WORD = 64'h0C28_F22C_ED7D_0E24;
    localparam logic [BYTE_W-1:0] HDR_BASE = 8'hA0;

    typedef enum logic [1:0] {
        SEG_SYNC,
        SEG_HDR,
        SEG_PAYLOAD
    } seg_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
    } beat_t;

    function automatic seg_e seg_of(input int unsigned pos);
        if (pos < SYNC_LEN)     return SEG_SYNC;
        else if (pos < HDR_LEN) return SEG_HDR;
        else                    return SEG_PAYLOAD;
    endfunction

    function automatic logic [BYTE_W-1:0] pattern_byte(input int unsigned pos);
        logic [SYNC_LEN*BYTE_W-1:0] sw;
        case (seg_of(pos))
            SEG_SYNC: begin
                sw = SYNC_WORD >> (BYTE_W * (SYNC_LEN - 1 - pos));
                return sw[BYTE_W-1:0];
            end
            SEG_HDR:  return BYTE_W'(HDR_BASE + pos);
            default:  return BYTE_W'(pos - HDR_LEN);
        endcase
    endfunction

endpackage

// File: rtl/tpg_pos_ctr.sv
module tpg_pos_ctr #(
    parameter int FRAME_LEN = tpg_pkg::FRAME_LEN,
    parameter int FCNT_W    = tpg_pkg::FCNT_W,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [POS_W-1:0]  pos,
    output logic [FCNT_W-1:0] frames
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            frames <= '0;
        end else if (step) begin
            if (pos == LAST) begin
                pos    <= '0;
                frames <= frames + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    p_pos_range_r5: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

    p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(frames) |-> ($past(pos) == LAST && frames == $past(frames) + 1'b1));

    p_pos_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pos));

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern #(
    parameter int FRAME_LEN = tpg_pkg::FRAME_LEN,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic [POS_W-1:0] pos,
    output tpg_pkg::beat_t   beat
);
    always_comb begin
        beat.data = tpg_pkg::pattern_byte(int'(pos));
        beat.sof  = (pos == '0);
    end
endmodule

// File: rtl/tpg_serializer.sv
module tpg_serializer #(
    parameter int BYTE_W = tpg_pkg::BYTE_W,
    localparam int IDX_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic              take,
    output logic              ser_bit,
    output logic              ser_valid
);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(BYTE_W - 1);

    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] shreg;

    assign take    = en && (idx == '0);
    assign ser_bit = shreg[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            shreg     <= '0;
            ser_valid <= 1'b0;
        end else begin
            ser_valid <= en;
            if (en) begin
                shreg <= take ? din : (shreg << 1);
                idx   <= (idx == LAST_BIT) ? '0 : idx + 1'b1;
            end
        end
    end

    p_shift_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(shreg) && !ser_valid));

    p_load_msb_r8: assert property (@(posedge clk) disable iff (rst)
        take |=> ser_bit == $past(din[BYTE_W-1]));

endmodule

// File: rtl/tpg_frame_source.sv
module tpg_frame_source #(
    parameter int FRAME_LEN = tpg_pkg::FRAME_LEN,
    parameter int FCNT_W    = tpg_pkg::FCNT_W,
    parameter bit SER_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [7:0]        byte_data,
    output logic              byte_valid,
    output logic              sof,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic [FCNT_W-1:0] frame_count
);
    import tpg_pkg::*;

    localparam int POS_W = $clog2(FRAME_LEN);

    logic [POS_W-1:0] pos;
    beat_t            cur;
    logic             adv;

    tpg_pos_ctr #(.FRAME_LEN(FRAME_LEN), .FCNT_W(FCNT_W)) u_pos (
        .clk(clk), .rst(rst), .step(adv), .pos(pos), .frames(frame_count)
    );

    tpg_pattern #(.FRAME_LEN(FRAME_LEN)) u_pat (
        .pos(pos), .beat(cur)
    );

    generate
        if (SER_EN) begin : g_ser
            tpg_serializer #(.BYTE_W(BYTE_W)) u_ser (
                .clk(clk), .rst(rst), .en(en), .din(cur.data),
                .take(adv), .ser_bit(ser_bit), .ser_valid(ser_valid)
            );

            p_byte_in_bit_r10: assert property (@(posedge clk) disable iff (rst)
                byte_valid |-> ser_valid);

            p_msb_first_r8: assert property (@(posedge clk) disable iff (rst)
                byte_valid |-> ser_bit == byte_data[7]);
        end else begin : g_par
            assign adv       = en;
            assign ser_bit   = 1'b0;
            assign ser_valid = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_data  <= '0;
            byte_valid <= 1'b0;
            sof        <= 1'b0;
        end else begin
            byte_valid <= adv;
            sof        <= adv && cur.sof;
            if (adv) byte_data <= cur.data;
        end
    end

    p_sof_in_byte_r6: assert property (@(posedge clk) disable iff (rst)
        sof |-> byte_valid);

    p_sof_sync_r2: assert property (@(posedge clk) disable iff (rst)
        sof |-> byte_data == 8'h0C);

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !byte_valid);

endmodule

// File: tb/tpg_frame_source_tb.sv
module tpg_frame_source_tb;

    localparam int FLEN   = 2400;
    localparam int TARGET = 2 * FLEN + 10;
    localparam logic [63:0] SYNC64 = 64'h0C28F22CED7D0E24;

    typedef struct {
        logic [7:0] d;
        bit         s;
        int         f;
        int         p;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [7:0]  byte_data;
    logic        byte_valid, sof, ser_bit, ser_valid;
    logic [23:0] frame_count;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   consumed = 0;
    bit   mon_on  = 1'b0;
    logic en_s    = 1'b0;

    exp_t q[$];
    exp_t cur_exp;
    int   mbit = 0;
    logic [7:0]  sacc;
    logic [63:0] s64;
    int   s64_n = -1;

    always #2 clk = ~clk;

    tpg_frame_source u_dut (
        .clk(clk), .rst(rst), .en(en),
        .byte_data(byte_data), .byte_valid(byte_valid), .sof(sof),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .frame_count(frame_count)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input int p);
        logic [7:0] sync_tab [8] = '{8'h0C, 8'h28, 8'hF2, 8'h2C, 8'hED, 8'h7D, 8'h0E, 8'h24};
        if (p < 8)       return sync_tab[p];
        else if (p < 16) return 8'(8'hA0 + p);
        else             return 8'((p - 16) % 256);
    endfunction

    task automatic push_stream(input int n);
        exp_t e;
        q.delete();
        for (int i = 0; i < n; i++) begin
            e.p = i % FLEN;
            e.f = i / FLEN;
            e.d = ref_byte(e.p);
            e.s = (e.p == 0);
            q.push_back(e);
        end
    endtask

    always @(posedge clk) en_s <= en;

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk(ser_valid == en_s, "R9 ser_valid follows enable", ser_valid, en_s);
            if (!ser_valid)
                chk(!byte_valid, "R9 no byte while paused", byte_valid, 0);
            if (ser_valid) begin
                chk(byte_valid == (mbit == 0), "R10 byte_valid on first bit", byte_valid, mbit == 0);
                if (byte_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R5 scoreboard underflow", 0, 1);
                    end else begin
                        cur_exp = q.pop_front();
                        consumed++;
                        if (cur_exp.p < 8)
                            chk(byte_data == cur_exp.d, "R2 sync byte", byte_data, cur_exp.d);
                        else if (cur_exp.p < 16)
                            chk(byte_data == cur_exp.d, "R3 header byte", byte_data, cur_exp.d);
                        else
                            chk(byte_data == cur_exp.d, "R4 payload byte", byte_data, cur_exp.d);
                        chk(sof == cur_exp.s, "R6 sof marker", sof, cur_exp.s);
                        chk(int'(frame_count) == cur_exp.f + (cur_exp.p == FLEN - 1 ? 1 : 0),
                            "R7 frame count", frame_count,
                            cur_exp.f + (cur_exp.p == FLEN - 1 ? 1 : 0));
                        if (sof) s64_n = 0;
                    end
                    sacc = {7'd0, ser_bit};
                    mbit = 1;
                end else begin
                    chk(!sof, "R6 sof outside byte", sof, 0);
                    sacc = {sacc[6:0], ser_bit};
                    mbit++;
                end
                if (s64_n >= 0) begin
                    s64 = {s64[62:0], ser_bit};
                    s64_n++;
                    if (s64_n == 64) begin
                        chk(s64 == SYNC64, "R8 serial sync word", s64, SYNC64);
                        s64_n = -1;
                    end
                end
                if (mbit == 8) begin
                    chk(sacc == cur_exp.d, "R8 serial byte msb first", sacc, cur_exp.d);
                    mbit = 0;
                end
            end else begin
                chk(!sof, "R6 sof while idle", sof, 0);
            end
        end
    end

    task automatic check_reset_state();
        @(negedge clk);
        chk(byte_data == 8'h00, "R1 reset byte_data", byte_data, 0);
        chk(!byte_valid, "R1 reset byte_valid", byte_valid, 0);
        chk(!sof, "R1 reset sof", sof, 0);
        chk(!ser_bit, "R1 reset ser_bit", ser_bit, 0);
        chk(!ser_valid, "R1 reset ser_valid", ser_valid, 0);
        chk(frame_count == 0, "R1 reset frame_count", frame_count, 0);
    endtask

    task automatic apply_reset();
        mon_on = 1'b0;
        @(posedge clk); #1;
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_reset_state();
        push_stream(TARGET + 20);
        mbit     = 0;
        s64_n    = -1;
        consumed = 0;
        mon_on   = 1'b1;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [23:0] fc_hold = '0;
        apply_reset();
        for (int c = 0; c < 400; c++) begin
            @(posedge clk); #1;
            en = (c % 3 != 2);
        end
        apply_reset();
        for (int c = 0; c < 150000 && consumed < TARGET; c++) begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (c < 3000)
                en = 1'b1;
            else if (c >= 30000 && c < 30200)
                en = 1'b0;
            else
                en = (lfsr[1:0] != 2'b00);
            if (c == 30003) fc_hold = frame_count;
            if (c == 30199)
                chk(frame_count == fc_hold && !byte_valid, "R9 state held in pause",
                    frame_count, fc_hold);
        end
        @(posedge clk); #1 en = 1'b0;
        repeat (2) @(negedge clk);
        chk(consumed >= TARGET, "R5 stream crossed two frame wraps", consumed, TARGET);
        chk(frame_count == 2, "R7 two frames completed", frame_count, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule